// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer

This block takes a stream of three-component pixels (RGB or YCbCr, one component per lane) and lowers the number of meaningful bits per component. It does this either by cutting the low bits, with optional rounding, or by adding a small noise term before cutting. The noise comes from either a constant per-channel pattern or from pseudo-random generators. The result stays at the input width with the discarded low bits forced to zero, so later stages see a normal component word. The stream markers (valid, start of frame, end of line) travel alongside the pixel with the same one-cycle delay.

Each channel has its own 28-bit random generator and its own seed. The generators step once for every valid pixel. When frame reseeding is enabled, a small frame counter is mixed into the seeds at every start of frame, so that the noise pattern changes from frame to frame. The counter limit and the rotation of its bits depend on the selected dither depth. When frame reseeding is off, the generators start from their seeds only when the block leaves reset.

The configuration inputs are treated as static while pixels flow. Dithering takes precedence over truncation. When neither is enabled, the pixel passes through unchanged.

Top module: `bdr_top`

## Requirements
- R1: Each valid input pixel appears on the output exactly one clock later, with its start-of-frame and end-of-line flags. The output valid is low during reset and low one cycle after any cycle with input valid low. With dither and truncation both disabled, every component is output unchanged.
- R2: With truncation enabled, dither disabled and rounding off, each 12-bit component keeps its top 6 bits (depth code 0) or top 8 bits (depth code 1), and the lower bits are output as zero.
- R3: With rounding on, half of one kept LSB is added to the component before the low bits are cleared. A sum that passes 4095 gives all kept bits set and the low bits zero.
- R4: With dither enabled, truncation settings are ignored. Dither depth codes 0, 1, 2 and 3 keep 6, 8, 10 and 10 bits. The low D bits of the noise are added to the component, where D is 12 minus the kept bits, and the low D bits are then cleared. A sum above 4095 saturates as in R3.
- R5: In pattern mode (random select 0), the noise of each channel is the low 12 bits of that channel's own seed input.
- R6: In random mode (random select 1), the noise is the low 12 bits of the generator's current state. After each valid pixel the generator moves to {s[26:0], s[27]^s[2]}, the shift form of x^28+x^3+1. It does not move on cycles without a valid pixel.
- R7: With per-channel random on, channel R, G and B use their own generators, seeded by their own seeds. With it off, all three channels take noise from the R generator, while all three generators still step.
- R8: With highpass mixing on in random mode, the 12-bit noise is XORed with the state shifted right by 28-D, that is, the top D bits of the state.
- R9: With frame reseeding on, a valid start-of-frame pixel loads every generator with its seed XOR the frame count rotated left in 4 bits. That loaded value is used for the same pixel. The count then steps and wraps to 0 once it reaches the limit. The limit and rotation are 15 and 2 for depth codes 0 and 1, 3 and 1 for code 2, and 0 and 0 for code 3.
- R10: With frame reseeding off, the frame count is held at 0 and start-of-frame has no effect on the generators. The generators are loaded from the seeds only while reset is high.
- R11: A generator load value of zero, either at reset or at a frame reseed, is replaced by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Start of frame marker |
| in_eol | input | 1 | End of line marker |
| in_pix | input | 3*PIX_W | Input pixel {R, G, B} |
| trunc_en | input | 1 | Truncation enable |
| trunc_depth | input | 1 | Truncation depth: 0 keeps 6 bits, 1 keeps 8 bits |
| trunc_round | input | 1 | 1 adds half an LSB before cutting |
| dith_en | input | 1 | Dither enable |
| dith_rand | input | 1 | 0 constant seed pattern, 1 random generator |
| dith_depth | input | 2 | Dither depth code |
| hp_rand_en | input | 1 | Highpass noise mixing |
| frame_rand_en | input | 1 | Per-frame reseeding |
| rgb_rand_en | input | 1 | Independent generator per channel |
| seed_r | input | 28 | R channel seed |
| seed_g | input | 28 | G channel seed |
| seed_b | input | 28 | B channel seed |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output start of frame |
| out_eol | output | 1 | Output end of line |
| out_pix | output | 3*PIX_W | Reduced pixel {R, G, B} |

## Verification
Corner values near zero, at half-LSB boundaries and at full scale set plain truncation apart from rounding and show saturation under both. Random pixels with idle gaps between them are run in pattern mode and in random mode, with per-channel random on and off and with highpass mixing. These cases separate the noise source, the channel-to-generator mapping and the rule that the generators step only on valid pixels. Runs of short frames of more than sixteen frames, at each dither depth, exercise the frame counter's wrap and rotation. Frames sent with reseeding off, and zero seeds, show that start-of-frame is ignored and that a zero load value is replaced.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   localparam int RNG_W = 28;
   localparam int FC_W  = 4;

   typedef enum logic [1:0] {
      OP_PASS   = 2'd0,
      OP_TRUNC  = 2'd1,
      OP_ROUND  = 2'd2,
      OP_DITHER = 2'd3
   } red_op_e;

   function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
      return {s[RNG_W-2:0], s[RNG_W-1] ^ s[2]};
   endfunction

   function automatic logic [RNG_W-1:0] rng_fix(input logic [RNG_W-1:0] v);
      return (v == '0) ? RNG_W'(1) : v;
   endfunction
endpackage

// File: rtl/bdr_lfsr.sv
module bdr_lfsr
   import bdr_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             load,
   input  logic [RNG_W-1:0] seed,
   input  logic [RNG_W-1:0] load_val,
   output logic [RNG_W-1:0] cur
);
   logic [RNG_W-1:0] st;

   assign cur = load ? rng_fix(load_val) : st;

   always_ff @(posedge clk) begin
      if (rst)      st <= rng_fix(seed);
      else if (adv) st <= rng_next(cur);
   end

   // R11: a zero state would lock the generator
   p_rng_nonzero_r11: assert property (@(posedge clk) disable iff (rst) st != '0);
   // R6: generator holds without a valid pixel
   p_rng_hold_r6: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(st));
endmodule

// File: rtl/bdr_fcnt.sv
module bdr_fcnt
   import bdr_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            frame_en,
   input  logic            tick,
   input  logic [1:0]      depth,
   output logic            load,
   output logic [FC_W-1:0] swz
);
   localparam int RW = $clog2(FC_W + 1);

   logic [FC_W-1:0] cnt, lim;
   logic [RW-1:0]   rot;

   always_comb begin
      case (depth)
         2'd0, 2'd1: begin lim = FC_W'(15); rot = RW'(2); end
         2'd2:       begin lim = FC_W'(3);  rot = RW'(1); end
         default:    begin lim = '0;        rot = '0;     end
      endcase
   end

   assign swz  = (cnt << rot) | (cnt >> (RW'(FC_W) - rot));
   assign load = tick & frame_en;

   always_ff @(posedge clk) begin
      if (rst || !frame_en) cnt <= '0;
      else if (tick)        cnt <= (cnt >= lim) ? '0 : cnt + FC_W'(1);
   end

   // R9: count wraps at the depth-dependent limit
   p_fcnt_wrap_r9: assert property (@(posedge clk) disable iff (rst)
      (load && cnt >= lim) |=> cnt == '0);
   // R10: count held at zero while reseeding is off
   p_fcnt_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !frame_en |=> cnt == '0);
endmodule

// File: rtl/bdr_chan.sv
module bdr_chan
   import bdr_pkg::*;
#(
   parameter int PIX_W    = 12,
   parameter int KEEP_LO  = 6,
   parameter int KEEP_MID = 8,
   parameter int KEEP_HI  = 10
) (
   input  red_op_e          op,
   input  logic [1:0]       keep_sel,
   input  logic             rand_mode,
   input  logic             hp_en,
   input  logic [PIX_W-1:0] x,
   input  logic [PIX_W-1:0] seed_lo,
   input  logic [RNG_W-1:0] rng,
   output logic [PIX_W-1:0] y
);
   localparam int DW = $clog2(PIX_W + 1);
   localparam int SW = $clog2(RNG_W + 1);

   logic [DW-1:0]    drop;
   logic [SW-1:0]    hp_sh;
   logic [PIX_W-1:0] mask, noise, addend;
   logic [PIX_W:0]   sum;

   always_comb begin
      case (keep_sel)
         2'd0:    drop = DW'(PIX_W - KEEP_LO);
         2'd1:    drop = DW'(PIX_W - KEEP_MID);
         default: drop = DW'(PIX_W - KEEP_HI);
      endcase
      mask  = (PIX_W'(1) << drop) - PIX_W'(1);
      hp_sh = SW'(RNG_W) - SW'(drop);
      if (rand_mode)
         noise = rng[PIX_W-1:0] ^ (hp_en ? PIX_W'(rng >> hp_sh) : '0);
      else
         noise = seed_lo;
      case (op)
         OP_DITHER: addend = noise & mask;
         OP_ROUND:  addend = PIX_W'(1) << (drop - DW'(1));
         default:   addend = '0;
      endcase
      sum = {1'b0, x} + {1'b0, addend};
      if (op == OP_PASS)  y = x;
      else if (sum[PIX_W]) y = ~mask;
      else                 y = sum[PIX_W-1:0] & ~mask;
   end

   // R2: reduced output never carries bits below the kept depth
   always_comb begin
      if (op != OP_PASS) p_low_clear_r2: assert ((y & mask) == '0);
   end
endmodule

// File: rtl/bdr_top.sv
module bdr_top
   import bdr_pkg::*;
#(
   parameter int PIX_W    = 12,
   parameter int KEEP_LO  = 6,
   parameter int KEEP_MID = 8,
   parameter int KEEP_HI  = 10
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic                 in_eol,
   input  logic [3*PIX_W-1:0]   in_pix,
   input  logic                 trunc_en,
   input  logic                 trunc_depth,
   input  logic                 trunc_round,
   input  logic                 dith_en,
   input  logic                 dith_rand,
   input  logic [1:0]           dith_depth,
   input  logic                 hp_rand_en,
   input  logic                 frame_rand_en,
   input  logic                 rgb_rand_en,
   input  logic [RNG_W-1:0]     seed_r,
   input  logic [RNG_W-1:0]     seed_g,
   input  logic [RNG_W-1:0]     seed_b,
   output logic                 out_valid,
   output logic                 out_sof,
   output logic                 out_eol,
   output logic [3*PIX_W-1:0]   out_pix
);
   localparam int NCH = 3;

   if (PIX_W > RNG_W || PIX_W <= KEEP_HI || KEEP_LO < 1 ||
       KEEP_LO >= KEEP_MID || KEEP_MID >= KEEP_HI) begin : g_bad_params
      $error("bdr_top: depth parameters out of range");
   end

   red_op_e          op;
   logic [1:0]       keep_sel;
   logic             rs_load;
   logic [FC_W-1:0]  rs_swz;
   logic [RNG_W-1:0] seeds [NCH];
   logic [RNG_W-1:0] cur   [NCH];
   logic [3*PIX_W-1:0] red_pix;

   assign seeds[0] = seed_r;
   assign seeds[1] = seed_g;
   assign seeds[2] = seed_b;

   always_comb begin
      if (dith_en)       op = OP_DITHER;
      else if (trunc_en) op = trunc_round ? OP_ROUND : OP_TRUNC;
      else               op = OP_PASS;
      keep_sel = dith_en ? dith_depth : {1'b0, trunc_depth};
   end

   bdr_fcnt u_fcnt (
      .clk      (clk),
      .rst      (rst),
      .frame_en (frame_rand_en),
      .tick     (in_valid & in_sof),
      .depth    (dith_depth),
      .load     (rs_load),
      .swz      (rs_swz)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [RNG_W-1:0] rng_sel;
      logic [PIX_W-1:0] y_c;

      bdr_lfsr u_lfsr (
         .clk      (clk),
         .rst      (rst),
         .adv      (in_valid),
         .load     (rs_load),
         .seed     (seeds[c]),
         .load_val (seeds[c] ^ RNG_W'(rs_swz)),
         .cur      (cur[c])
      );

      assign rng_sel = rgb_rand_en ? cur[c] : cur[0];

      bdr_chan #(
         .PIX_W    (PIX_W),
         .KEEP_LO  (KEEP_LO),
         .KEEP_MID (KEEP_MID),
         .KEEP_HI  (KEEP_HI)
      ) u_chan (
         .op        (op),
         .keep_sel  (keep_sel),
         .rand_mode (dith_rand),
         .hp_en     (hp_rand_en),
         .x         (in_pix[(NCH-1-c)*PIX_W +: PIX_W]),
         .seed_lo   (seeds[c][PIX_W-1:0]),
         .rng       (rng_sel),
         .y         (y_c)
      );

      assign red_pix[(NCH-1-c)*PIX_W +: PIX_W] = y_c;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid;
         out_sof   <= in_valid & in_sof;
         out_eol   <= in_valid & in_eol;
         out_pix   <= red_pix;
      end
   end

   // R1: one-cycle latency of the valid marker
   p_latency_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_gap_r1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R1: bypass keeps the pixel
   p_pass_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !dith_en && !trunc_en) |=> out_pix == $past(in_pix));
   // R2: 6-bit truncation clears the low bits of the R lane
   p_trunc_lo_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !dith_en && trunc_en && !trunc_depth)
      |=> out_pix[2*PIX_W +: (PIX_W-KEEP_LO)] == '0);
endmodule

// File: tb/test_bdr_top.sv
`timescale 1ns/1ps
module test_bdr_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
   logic [35:0] in_pix = '0;
   logic        trunc_en = 0, trunc_depth = 0, trunc_round = 0;
   logic        dith_en = 0, dith_rand = 0;
   logic [1:0]  dith_depth = 0;
   logic        hp_rand_en = 0, frame_rand_en = 0, rgb_rand_en = 0;
   logic [27:0] seed_r = 28'h1234567, seed_g = 28'h89ABCDE, seed_b = 28'h0F1E2D3;
   logic        out_valid, out_sof, out_eol;
   logic [35:0] out_pix;

   int n_tests = 0, n_fail = 0, n_pushed = 0, n_popped = 0;
   bit done = 0;
   logic [37:0] exp_q [$];
   string       tag_q [$];
   logic [27:0] m_rng [3];
   logic [3:0]  m_fc;

   always #2.5 clk = ~clk;

   bdr_top i_bdr_top (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
      .in_pix(in_pix), .trunc_en(trunc_en), .trunc_depth(trunc_depth),
      .trunc_round(trunc_round), .dith_en(dith_en), .dith_rand(dith_rand),
      .dith_depth(dith_depth), .hp_rand_en(hp_rand_en), .frame_rand_en(frame_rand_en),
      .rgb_rand_en(rgb_rand_en), .seed_r(seed_r), .seed_g(seed_g), .seed_b(seed_b),
      .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
   );

   function automatic logic [27:0] m_step(input logic [27:0] s);
      logic fb;
      fb = s[27] ^ s[2];
      return {s[26:0], fb};
   endfunction

   function automatic logic [27:0] m_fix(input logic [27:0] v);
      if (v == 28'd0) return 28'd1;
      return v;
   endfunction

   function automatic logic [11:0] ref_reduce(input logic [11:0] x, input logic [27:0] rng,
                                              input logic [27:0] sd);
      int keep, drop, msk, n, add, s;
      if (!dith_en && !trunc_en) return x;
      if (dith_en) keep = (dith_depth == 2'd0) ? 6 : (dith_depth == 2'd1) ? 8 : 10;
      else         keep = trunc_depth ? 8 : 6;
      drop = 12 - keep;
      msk  = (1 << drop) - 1;
      if (dith_en) begin
         if (dith_rand) begin
            n = int'(rng[11:0]);
            if (hp_rand_en) n = n ^ int'(rng >> (28 - drop));
         end else n = int'(sd[11:0]);
         add = n & msk;
      end else add = trunc_round ? (1 << (drop - 1)) : 0;
      s = int'(x) + add;
      if (s > 4095) return 12'(4095 & ~msk);
      return 12'(s & ~msk);
   endfunction

   task automatic do_reset();
      rst = 1'b1; in_valid = 0; in_sof = 0; in_eol = 0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      m_rng[0] = m_fix(seed_r); m_rng[1] = m_fix(seed_g); m_rng[2] = m_fix(seed_b);
      m_fc = 4'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk); #1;
         in_valid = 0; in_sof = 0; in_eol = 0;
      end
      if (!frame_rand_en) m_fc = 4'd0;
   endtask

   task automatic send(input logic [11:0] r, g, b, input logic sof, eol, input string tag);
      logic [27:0] cur [3];
      logic [27:0] sd [3];
      logic [11:0] xs [3];
      logic [7:0]  two;
      logic [3:0]  sw;
      logic [35:0] e;
      int lim, rot;
      sd[0] = seed_r; sd[1] = seed_g; sd[2] = seed_b;
      xs[0] = r; xs[1] = g; xs[2] = b;
      if (!frame_rand_en) m_fc = 4'd0;
      if (dith_depth < 2)       begin lim = 15; rot = 2; end
      else if (dith_depth == 2) begin lim = 3;  rot = 1; end
      else                      begin lim = 0;  rot = 0; end
      two = {m_fc, m_fc} << rot;
      sw  = two[7:4];
      for (int c = 0; c < 3; c++)
         cur[c] = (frame_rand_en && sof) ? m_fix(sd[c] ^ {24'd0, sw}) : m_rng[c];
      for (int c = 0; c < 3; c++)
         e[(2-c)*12 +: 12] = ref_reduce(xs[c], rgb_rand_en ? cur[c] : cur[0], sd[c]);
      for (int c = 0; c < 3; c++) m_rng[c] = m_step(cur[c]);
      if (frame_rand_en && sof) m_fc = (int'(m_fc) >= lim) ? 4'd0 : m_fc + 4'd1;
      exp_q.push_back({sof, eol, e});
      tag_q.push_back(tag);
      n_pushed++;
      @(posedge clk); #1;
      in_valid = 1; in_sof = sof; in_eol = eol; in_pix = {r, g, b};
   endtask

   task automatic send_rand(input int n, input int gap, input string tag);
      for (int i = 0; i < n; i++) begin
         send(12'($urandom), 12'($urandom), 12'($urandom), 1'b0, (i % 4) == 3, tag);
         if (gap > 0) idle(gap);
      end
   endtask

   task automatic frames(input int nf, input int len, input string tag);
      for (int f = 0; f < nf; f++)
         for (int p = 0; p < len; p++)
            send(12'($urandom), 12'($urandom), 12'($urandom), p == 0, p == len - 1, tag);
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] act, exp_v);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) check(1'b0, "R1 unexpected output", 64'(out_pix), 64'd0);
         else begin
            logic [37:0] ev;
            string tg;
            ev = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_popped++;
            check({out_sof, out_eol, out_pix} == ev, tg,
                  64'({out_sof, out_eol, out_pix}), 64'(ev));
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      check(out_valid == 1'b0 && out_pix == '0, "R1 reset state",
            64'({out_valid, out_pix}), 64'd0);

      // R1 bypass, markers and latency
      send(12'hABC, 12'h123, 12'hFFF, 1'b1, 1'b0, "R1 pass");
      send(12'h000, 12'h7FF, 12'h801, 1'b0, 1'b1, "R1 pass");
      idle(2);
      send_rand(6, 1, "R1 pass gaps");
      idle(2);

      // R2 plain truncation
      trunc_en = 1; trunc_depth = 0; trunc_round = 0;
      send(12'hFFF, 12'h03F, 12'h840, 1'b0, 1'b0, "R2 trunc 6b");
      send_rand(4, 0, "R2 trunc 6b");
      idle(2);
      trunc_depth = 1;
      send(12'hFFF, 12'h00F, 12'h7F3, 1'b0, 1'b0, "R2 trunc 8b");
      send_rand(4, 0, "R2 trunc 8b");
      idle(2);

      // R3 rounding and saturation
      trunc_round = 1; trunc_depth = 0;
      send(12'hFFF, 12'h020, 12'h01F, 1'b0, 1'b0, "R3 round 6b");
      send(12'hFE0, 12'hFDF, 12'h000, 1'b0, 1'b0, "R3 round 6b sat");
      idle(2);
      trunc_depth = 1;
      send(12'hFF8, 12'h008, 12'h007, 1'b0, 1'b0, "R3 round 8b");
      send_rand(4, 0, "R3 round 8b");
      idle(2);

      // R4/R5 dither over truncation, pattern mode, all depth codes
      dith_en = 1; dith_rand = 0;
      for (int d = 0; d < 4; d++) begin
         dith_depth = 2'(d);
         idle(1);
         send(12'hFFF, 12'h000, 12'h7C0, 1'b0, 1'b0, "R4 R5 pattern");
         send_rand(4, 0, "R4 R5 pattern");
         idle(2);
      end

      // R6/R7 random mode, per-channel, with gaps
      dith_rand = 1; rgb_rand_en = 1; dith_depth = 0;
      idle(1);
      send_rand(10, 2, "R6 R7 random per-channel");
      dith_depth = 2;
      idle(1);
      send_rand(10, 0, "R6 random depth2");
      idle(2);
      rgb_rand_en = 0;
      idle(1);
      send_rand(10, 1, "R7 shared generator");
      idle(2);

      // R8 highpass mixing
      hp_rand_en = 1; rgb_rand_en = 1;
      for (int d = 0; d < 3; d++) begin
         dith_depth = 2'(d);
         idle(1);
         send_rand(8, 0, "R8 highpass");
         idle(2);
      end
      hp_rand_en = 0;

      // R10 start-of-frame ignored with reseeding off
      dith_depth = 0;
      idle(1);
      frames(4, 3, "R10 sof no reseed");
      idle(2);

      // R9 frame reseeding, wrap and rotation per depth
      frame_rand_en = 1; dith_depth = 0;
      idle(1);
      frames(20, 2, "R9 reseed depth0");
      idle(2);
      dith_depth = 1;
      idle(1);
      frames(18, 2, "R9 reseed depth1");
      idle(2);
      dith_depth = 2;
      idle(1);
      frames(7, 3, "R9 reseed depth2");
      idle(2);
      dith_depth = 3;
      idle(1);
      frames(3, 2, "R9 reseed depth3");
      idle(2);
      frame_rand_en = 0;
      idle(2);
      frames(2, 2, "R10 reseed off again");
      idle(2);

      // R11 zero seeds
      seed_r = 28'd0; seed_g = 28'd0;
      dith_depth = 1;
      do_reset();
      send_rand(6, 0, "R11 zero seed reset");
      idle(2);
      frame_rand_en = 1;
      idle(1);
      frames(3, 2, "R11 zero seed reseed");
      idle(4);

      check(exp_q.size() == 0 && n_popped == n_pushed, "R1 output count",
            64'(n_popped), 64'(n_pushed));
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule